// File: doc/BRIEF.md
# Indirect Interrupt Redirection Table Front End

This block is the register front end of an I/O interrupt controller. It holds a table of redirection entries. Each entry has an 8-bit interrupt vector and a remote-IRR status bit, which shows that a level interrupt has been delivered and not yet acknowledged. Software reaches the table indirectly. It first writes an 8-bit selector register, then reads or writes a 32-bit data window that maps onto the word that selector points at.

Delivery logic outside the block raises one set pulse per entry when it hands a level interrupt to a processor. That pulse sets the entry's remote-IRR bit. Software acknowledges with a write to a write-only end-of-interrupt port. One write compares its low byte against the vector of every entry at the same time and clears remote-IRR on all entries that match, in the same clock cycle. Bus writes take effect on the rising clock edge. Read data is combinational from the current address, byte enables and stored state.

Top module: `intr_redir_regs`

## Requirements
- R1: The selector register sits at byte offset 0x00 and is 8 bits wide. A write there with be[0] set loads wdata[7:0]. A write with be[0] clear leaves it unchanged. A read at 0x00 returns the selector zero-extended to 32 bits.
- R2: The data window sits at offset 0x10 and accepts only full accesses. A write whose byte enables are not 4'hF is ignored. A read whose byte enables are not 4'hF returns zero.
- R3: Selector value 0x10+2n maps the window to the low word of entry n, with the vector in bits 7:0 and remote-IRR in bit 14. Selector value 0x11+2n maps it to the high word of entry n. Every bit of both words other than bit 14 of the low word is stored as written and read back unchanged.
- R4: Selector values below 0x10, or at or above 0x10 plus twice the entry count, select nothing. Window reads then return zero and window writes change no entry.
- R5: Bit 14 of a low word is read-only through the window. A window write leaves remote-IRR unchanged whatever its bit 14 holds.
- R6: A high level on set input n during a clock edge sets remote-IRR of entry n. The bit reads back as 1 from the next cycle on.
- R7: A write to offset 0x40 with be[0] set is an end-of-interrupt. Its wdata[7:0] is compared with the vector of every entry. Every matching entry has remote-IRR cleared in the same cycle. wdata[31:8] has no effect, and a write there with be[0] clear does nothing.
- R8: When a set pulse and a matching end-of-interrupt hit the same entry on the same edge, remote-IRR ends up set.
- R9: A read at offset 0x40, or at any offset other than 0x00 and 0x10, returns zero.
- R10: After reset the selector, every stored word and every remote-IRR bit are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write enable for the current cycle |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr and bus_be |
| rirr_set | input | NUM_ENTRIES | One set pulse per entry, marks a level interrupt as delivered |

## Verification
The assertions check on every cycle that:
- a set pulse always leaves remote-IRR high, including against a same-cycle end-of-interrupt;
- an end-of-interrupt clears every matching entry that has no set pulse;
- remote-IRR never rises without a pulse and never falls without an end-of-interrupt;
- the selector loads its byte;
- partial window reads and reads of the end-of-interrupt port return zero.

The bench scenarios show what needs a bus sequence:
- the word layout behind each selector value, and the preserved storage bits;
- the dead selector ranges;
- bit 14 of the window staying read-only while remote-IRR is set and while it is clear;
- upper end-of-interrupt bits being ignored, with several entries sharing one vector.

// File: rtl/irt_pkg.sv
package irt_pkg;

  localparam int unsigned BUS_AW   = 8;
  localparam int unsigned BUS_DW   = 32;
  localparam int unsigned BUS_BEW  = BUS_DW / 8;
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned SEL_W    = 8;
  localparam int unsigned RIRR_BIT = 14;

  localparam logic [BUS_AW-1:0] OFF_SELECT = 8'h00;
  localparam logic [BUS_AW-1:0] OFF_WINDOW = 8'h10;
  localparam logic [BUS_AW-1:0] OFF_EOI    = 8'h40;

  // first selector value that lands on the table; must be even
  localparam logic [SEL_W-1:0] TABLE_SEL_BASE = 8'h10;

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_SELECT = 2'd1,
    RD_WINDOW = 2'd2
  } rd_src_t;

  typedef struct packed {
    logic             hit;
    logic             hi;
    logic [SEL_W-1:0] slot;
  } tbl_sel_t;

  // Selector value -> (valid, high word, entry number)
  function automatic tbl_sel_t decode_select(input logic [SEL_W-1:0] sel,
                                             input int unsigned      n_ent);
    tbl_sel_t   s;
    logic [SEL_W:0] rel;
    s   = '0;
    rel = {1'b0, sel} - {1'b0, TABLE_SEL_BASE};
    if ((sel >= TABLE_SEL_BASE) && (rel < (SEL_W+1)'(2 * n_ent))) begin
      s.hit  = 1'b1;
      s.hi   = rel[0];
      s.slot = rel[SEL_W:1];
    end
    return s;
  endfunction

  // Low word as software sees it: stored bits with the live remote-IRR in place
  function automatic logic [BUS_DW-1:0] place_rirr(input logic [BUS_DW-1:0] word,
                                                   input logic              rirr);
    logic [BUS_DW-1:0] m;
    m           = word;
    m[RIRR_BIT] = rirr;
    return m;
  endfunction

  function automatic logic full_word(input logic [BUS_BEW-1:0] be);
    return &be;
  endfunction

endpackage

// File: rtl/irt_bus_decode.sv
module irt_bus_decode
  import irt_pkg::*;
(
  input  logic [BUS_AW-1:0]  addr,
  input  logic               we,
  input  logic [BUS_BEW-1:0] be,
  input  logic [VEC_W-1:0]   wdata_lo,
  output logic               sel_wr,
  output logic               win_wr,
  output logic               eoi_fire,
  output logic [VEC_W-1:0]   eoi_vec,
  output rd_src_t            rd_src
);

  logic at_sel, at_win, at_eoi, whole;

  always_comb begin
    at_sel = (addr == OFF_SELECT);
    at_win = (addr == OFF_WINDOW);
    at_eoi = (addr == OFF_EOI);
    whole  = full_word(be);

    sel_wr   = we && at_sel && be[0];
    win_wr   = we && at_win && whole;
    eoi_fire = we && at_eoi && be[0];
    eoi_vec  = wdata_lo;

    if (at_sel)               rd_src = RD_SELECT;
    else if (at_win && whole) rd_src = RD_WINDOW;
    else                      rd_src = RD_ZERO;
  end

endmodule

// File: rtl/irt_entry.sv
module irt_entry
  import irt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BUS_DW-1:0] wdata,
  input  logic              set_pulse,
  input  logic              eoi_fire,
  input  logic [VEC_W-1:0]  eoi_vec,
  output logic [BUS_DW-1:0] lo_word,
  output logic [BUS_DW-1:0] hi_word,
  output logic              eoi_hit,
  output logic              rirr
);

  logic [BUS_DW-1:0] lo_q, hi_q;
  logic              rirr_q;

  // bit 14 of lo_q is never stored; remote-IRR lives in rirr_q only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (wr_lo) lo_q <= place_rirr(wdata, 1'b0);
      if (wr_hi) hi_q <= wdata;
    end
  end

  assign eoi_hit = eoi_fire && (lo_q[VEC_W-1:0] == eoi_vec);

  // set has priority over an end-of-interrupt clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rirr_q <= 1'b0;
    else if (set_pulse) rirr_q <= 1'b1;
    else if (eoi_hit)   rirr_q <= 1'b0;
  end

  assign lo_word = place_rirr(lo_q, rirr_q);
  assign hi_word = hi_q;
  assign rirr    = rirr_q;

endmodule

// File: rtl/irt_read_mux.sv
module irt_read_mux
  import irt_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24
) (
  input  rd_src_t                            rd_src,
  input  logic [SEL_W-1:0]                   sel_q,
  input  tbl_sel_t                           tsel,
  input  logic [NUM_ENTRIES-1:0][BUS_DW-1:0] lo_words,
  input  logic [NUM_ENTRIES-1:0][BUS_DW-1:0] hi_words,
  output logic [BUS_DW-1:0]                  rdata
);

  logic [BUS_DW-1:0] win_word;

  always_comb begin
    win_word = '0;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      if (tsel.hit && (tsel.slot == SEL_W'(k)))
        win_word = tsel.hi ? hi_words[k] : lo_words[k];
    end
  end

  always_comb begin
    unique case (rd_src)
      RD_SELECT: rdata = {{(BUS_DW-SEL_W){1'b0}}, sel_q};
      RD_WINDOW: rdata = win_word;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/intr_redir_regs.sv
module intr_redir_regs
  import irt_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             bus_addr,
  input  logic                   bus_we,
  input  logic [3:0]             bus_be,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NUM_ENTRIES-1:0] rirr_set
);

  localparam int unsigned MAX_ENTRIES = (256 - TABLE_SEL_BASE) / 2;

  logic [SEL_W-1:0]  sel_q;
  logic              sel_wr, win_wr, eoi_fire;
  logic [VEC_W-1:0]  eoi_vec;
  rd_src_t           rd_src;
  tbl_sel_t          tsel;

  logic [NUM_ENTRIES-1:0][BUS_DW-1:0] lo_words, hi_words;
  logic [NUM_ENTRIES-1:0]             eoi_hit;
  logic [NUM_ENTRIES-1:0]             rirr_vec;

  initial begin
    if (NUM_ENTRIES < 1 || NUM_ENTRIES > MAX_ENTRIES)
      $error("NUM_ENTRIES out of range");
  end

  irt_bus_decode dec_i (
    .addr     (bus_addr),
    .we       (bus_we),
    .be       (bus_be),
    .wdata_lo (bus_wdata[VEC_W-1:0]),
    .sel_wr   (sel_wr),
    .win_wr   (win_wr),
    .eoi_fire (eoi_fire),
    .eoi_vec  (eoi_vec),
    .rd_src   (rd_src)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_wr) sel_q <= bus_wdata[SEL_W-1:0];
  end

  assign tsel = decode_select(sel_q, NUM_ENTRIES);

  for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_entry
    logic picked;
    assign picked = tsel.hit && (tsel.slot == SEL_W'(n));

    irt_entry ent_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_lo     (win_wr && picked && !tsel.hi),
      .wr_hi     (win_wr && picked &&  tsel.hi),
      .wdata     (bus_wdata),
      .set_pulse (rirr_set[n]),
      .eoi_fire  (eoi_fire),
      .eoi_vec   (eoi_vec),
      .lo_word   (lo_words[n]),
      .hi_word   (hi_words[n]),
      .eoi_hit   (eoi_hit[n]),
      .rirr      (rirr_vec[n])
    );
  end

  irt_read_mux #(.NUM_ENTRIES(NUM_ENTRIES)) rmux_i (
    .rd_src   (rd_src),
    .sel_q    (sel_q),
    .tsel     (tsel),
    .lo_words (lo_words),
    .hi_words (hi_words),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/irt_checker.sv
module irt_checker
  import irt_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 24
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [7:0]             bus_addr,
  input logic                   bus_we,
  input logic [3:0]             bus_be,
  input logic [31:0]            bus_wdata,
  input logic [31:0]            bus_rdata,
  input logic [NUM_ENTRIES-1:0] rirr_set,
  input logic                   eoi_fire,
  input logic [NUM_ENTRIES-1:0] eoi_hit,
  input logic [NUM_ENTRIES-1:0] rirr_vec,
  input logic [7:0]             sel_q
);

  assert_select_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_SELECT && bus_be[0]) |=> (sel_q == $past(bus_wdata[7:0])));

  assert_partial_window_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_WINDOW && bus_be != 4'hF) |-> (bus_rdata == 32'h0));

  // R5: remote-IRR never rises without a pulse and never falls without an EOI
  assert_rirr_no_spurious_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rirr_vec & ~$past(rirr_vec) & ~$past(rirr_set)) == '0));

  assert_rirr_no_spurious_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi_fire |=> ((~rirr_vec & $past(rirr_vec)) == '0));

  assert_set_pulse_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rirr_set != '0) |=> ((rirr_vec & $past(rirr_set)) == $past(rirr_set)));

  assert_eoi_clears_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire |=> ((rirr_vec & $past(eoi_hit & ~rirr_set)) == '0));

  assert_eoi_hit_needs_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !eoi_fire |-> (eoi_hit == '0));

  assert_set_beats_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((eoi_hit & rirr_set) != '0) |=> ((rirr_vec & $past(eoi_hit & rirr_set)) == $past(eoi_hit & rirr_set)));

  assert_eoi_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_EOI) |-> (bus_rdata == 32'h0));

endmodule

bind intr_redir_regs irt_checker #(.NUM_ENTRIES(NUM_ENTRIES)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_be    (bus_be),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .rirr_set  (rirr_set),
  .eoi_fire  (eoi_fire),
  .eoi_hit   (eoi_hit),
  .rirr_vec  (rirr_vec),
  .sel_q     (sel_q)
);

// File: tb/intr_redir_regs_tb_top.sv
module intr_redir_regs_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NE         = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    bus_addr;
  logic          bus_we;
  logic [3:0]    bus_be;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NE-1:0] rirr_set;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  // behavioural reference state
  logic [31:0] m_lo [NE];
  logic [31:0] m_hi [NE];
  bit          m_rirr [NE];
  logic [7:0]  m_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_redir_regs #(.NUM_ENTRIES(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rirr_set(rirr_set)
  );

  function automatic logic [31:0] model_read(logic [7:0] a, logic [3:0] be);
    int rel;
    if (a == 8'h00) return {24'h0, m_sel};
    if (a != 8'h10 || be != 4'hF) return 32'h0;
    rel = int'(m_sel) - 16;
    if (rel < 0 || rel >= 2 * NE) return 32'h0;
    if (rel % 2 == 1) return m_hi[rel / 2];
    return (m_lo[rel / 2] & ~32'h4000) | (m_rirr[rel / 2] ? 32'h4000 : 32'h0);
  endfunction

  task automatic model_step(logic [7:0] a, bit we, logic [3:0] be,
                            logic [31:0] wd, logic [NE-1:0] st);
    int rel;
    if (we) begin
      if (a == 8'h00 && be[0]) m_sel = wd[7:0];
      else if (a == 8'h10 && be == 4'hF) begin
        rel = int'(m_sel) - 16;
        if (rel >= 0 && rel < 2 * NE) begin
          if (rel % 2 == 1) m_hi[rel / 2] = wd;
          else              m_lo[rel / 2] = wd & ~32'h4000;
        end
      end else if (a == 8'h40 && be[0]) begin
        for (int k = 0; k < NE; k++)
          if (m_lo[k][7:0] == wd[7:0]) m_rirr[k] = 0;
      end
    end
    for (int k = 0; k < NE; k++)
      if (st[k]) m_rirr[k] = 1;
  endtask

  // one bus cycle: drive, compare read data against the model, advance
  task automatic cyc(logic [7:0] a, bit we, logic [3:0] be, logic [31:0] wd,
                     logic [NE-1:0] st, string tag);
    logic [31:0] exp;
    bus_addr = a; bus_we = we; bus_be = be; bus_wdata = wd; rirr_set = st;
    #1;
    exp = model_read(a, be);
    n_checks++;
    if (bus_rdata !== exp) begin
      n_fails++;
      $display("FAIL %s addr=%02h be=%h actual=%08h expected=%08h",
               tag, a, be, bus_rdata, exp);
    end
    model_step(a, we, be, wd, st);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [3:0] be, logic [31:0] wd, string tag);
    cyc(a, 1, be, wd, '0, tag);
  endtask

  task automatic rd(logic [7:0] a, logic [3:0] be, string tag);
    cyc(a, 0, be, 32'h0, '0, tag);
  endtask

  task automatic rd_entry(logic [7:0] s, string tag);
    wr(8'h00, 4'h1, {24'h0, s}, tag);
    rd(8'h10, 4'hF, tag);
  endtask

  initial begin
    for (int k = 0; k < NE; k++) begin m_lo[k] = 0; m_hi[k] = 0; m_rirr[k] = 0; end
    m_sel = 0;
    rst_n = 0; bus_addr = 0; bus_we = 0; bus_be = 0; bus_wdata = 0; rirr_set = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10 reset state
    rd(8'h00, 4'hF, "R10");
    rd(8'h10, 4'hF, "R10");
    // R1 selector
    wr(8'h00, 4'hF, 32'hFFFF_FF10, "R1");
    rd(8'h00, 4'hF, "R1");
    rd(8'h10, 4'hF, "R10");
    wr(8'h00, 4'hE, 32'h0000_0033, "R1");
    rd(8'h00, 4'hF, "R1");
    // R3 and R5: layout, bit 14 not stored
    wr(8'h10, 4'hF, 32'hDEAD_4041, "R5");
    rd(8'h10, 4'hF, "R3");
    wr(8'h00, 4'h1, 32'h11, "R3");
    wr(8'h10, 4'hF, 32'h1234_5678, "R3");
    rd(8'h10, 4'hF, "R3");
    wr(8'h00, 4'h1, 32'h1A, "R3");
    wr(8'h10, 4'hF, 32'h0000_0041, "R3");
    wr(8'h00, 4'h1, 32'h3E, "R3");
    wr(8'h10, 4'hF, 32'h8000_BF41, "R3");
    rd(8'h10, 4'hF, "R3");
    wr(8'h00, 4'h1, 32'h3F, "R3");
    wr(8'h10, 4'hF, 32'hCAFE_F00D, "R3");
    wr(8'h00, 4'h1, 32'h1E, "R3");
    wr(8'h10, 4'hF, 32'h0000_0042, "R3");
    // R2 partial accesses
    wr(8'h00, 4'h1, 32'h3F, "R2");
    wr(8'h10, 4'h7, 32'h1111_1111, "R2");
    rd(8'h10, 4'h3, "R2");
    rd(8'h10, 4'hF, "R2");
    // R4 selectors that hit no entry
    wr(8'h00, 4'h1, 32'h0F, "R4");
    wr(8'h10, 4'hF, 32'hFFFF_FFFF, "R4");
    rd(8'h10, 4'hF, "R4");
    wr(8'h00, 4'h1, 32'h40, "R4");
    wr(8'h10, 4'hF, 32'hFFFF_FFFF, "R4");
    rd(8'h10, 4'hF, "R4");
    wr(8'h00, 4'h1, 32'hFF, "R4");
    rd(8'h10, 4'hF, "R4");
    rd_entry(8'h10, "R4");
    rd_entry(8'h3F, "R4");
    // R6 set pulses
    cyc(8'h00, 0, 4'hF, 0, 24'h80_00A1, "R6");
    rd_entry(8'h10, "R6");
    rd_entry(8'h1A, "R6");
    rd_entry(8'h1E, "R6");
    rd_entry(8'h3E, "R6");
    // R5 window write with bit 14 clear keeps remote-IRR set
    wr(8'h00, 4'h1, 32'h10, "R5");
    wr(8'h10, 4'hF, 32'h0000_0041, "R5");
    rd(8'h10, 4'hF, "R5");
    // R7 end-of-interrupt clears every match, upper bits ignored
    wr(8'h40, 4'hF, 32'hABCD_EF41, "R7");
    rd_entry(8'h10, "R7");
    rd_entry(8'h1A, "R7");
    rd_entry(8'h3E, "R7");
    rd_entry(8'h1E, "R7");
    // R7 EOI without be[0] does nothing
    cyc(8'h00, 0, 4'hF, 0, 24'h00_0001, "R6");
    wr(8'h40, 4'hE, 32'h0000_0041, "R7");
    rd_entry(8'h10, "R7");
    // R8 set beats a simultaneous matching clear
    cyc(8'h40, 1, 4'hF, 32'h0000_0041, 24'h00_0020, "R8");
    rd_entry(8'h1A, "R8");
    rd_entry(8'h10, "R8");
    // R9 other addresses read zero
    rd(8'h40, 4'hF, "R9");
    rd(8'h44, 4'hF, "R9");
    rd(8'h20, 4'hF, "R9");

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule